// File: doc/BRIEF.md
# Inbound Address Window Translator

This block decides where an inbound memory access from an external bus lands in a 32-bit local address space. It holds six windows. Each window has a match base, a size given as a power-of-two exponent, a translation base and an enable bit. The lookup path is purely combinational. An incoming address with a valid strobe produces four outputs in the same cycle: a hit flag, the index of the selected window, the translated local address and an abort flag.

When windows overlap, window 5 wins whenever it is among the matching windows. Otherwise the lowest-numbered matching window is chosen. Selection happens before the enable bit is looked at. If the selected window is disabled, the access is aborted and not translated. An address that matches no window gives neither a hit nor an abort, so the bus side can ignore it.

Software programs the windows through a single-cycle write port. A write takes effect at the next clock edge.

Top module: `inb_addr_xlat`

## Requirements
- R1: After reset every window is disabled, has match base 0, translation base 0 and size exponent 12. A valid lookup of 0x0000_0123 therefore gives abort=1, hit=0, window 5. A valid lookup of 0x0001_0000 gives hit=0 and abort=0.
- R2: A window with size exponent n matches an address when address bits [31:n] equal match base bits [31:n]. Address bits below n are not compared.
- R3: On a hit, the local address is (translation base AND mask) OR (incoming address AND NOT mask), where mask has ones in bits [31:n].
- R4: The size exponent is written in cfg_wdata[5:0] with field code 1. Values below 12 are stored as 12, and values above 32 are stored as 32. An exponent of 32 makes the window match every address and pass the address through unchanged.
- R5: If the selected window is disabled, the outputs are abort=1, hit=0 and local address 0, and lk_win gives that window's index.
- R6: A valid address that matches no window gives hit=0, abort=0, lk_win=0 and local address 0.
- R7: When window 5 matches, it is selected regardless of which other windows also match.
- R8: When window 5 does not match and several windows do, the lowest-numbered matching window is selected.
- R9: A write with cfg_we=1 goes to window cfg_win. cfg_field selects the target: 0 for match base, 1 for size exponent, 2 for translation base, 3 for enable (cfg_wdata[0]). The lookup sees the write only after the next rising clock edge. A write with cfg_win of 6 or 7 changes no window.
- R10: With lk_valid=0, hit and abort are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_win | input | 3 | Window index for the write |
| cfg_field | input | 2 | Field select: 0 match base, 1 size exponent, 2 translation base, 3 enable |
| cfg_wdata | input | 32 | Write data |
| lk_valid | input | 1 | Lookup address valid |
| lk_addr_in | input | 32 | Incoming bus address |
| lk_hit | output | 1 | Address translated through an enabled window |
| lk_abort | output | 1 | Address selected a disabled window |
| lk_win | output | 3 | Index of the selected window |
| lk_addr | output | 32 | Translated local address (0 unless hit) |

## Verification
The bench builds the block with its default parameters: six windows, 32-bit addresses, a 4 KB minimum page and window 5 as the preferred window on overlap. These settings allow the full set of overlap cases to be exercised: window 5 beating a larger window, the lowest index winning when window 5 is absent, and a disabled window 5 forcing an abort over an enabled neighbour. The 32-bit width also makes the exponent clamp at both ends observable. A clamped exponent of 32 turns the translation into a pure pass-through.

// File: rtl/inb_xlat_pkg.sv
package inb_xlat_pkg;

    typedef enum logic [1:0] {
        FLD_MBASE  = 2'd0,
        FLD_SIZE   = 2'd1,
        FLD_TBASE  = 2'd2,
        FLD_ENABLE = 2'd3
    } cfg_field_e;

endpackage

// File: rtl/inb_win_regs.sv
module inb_win_regs
    import inb_xlat_pkg::*;
#(
    parameter int NUM_WIN = 6,
    parameter int ADDR_W  = 32,
    parameter int MIN_SZ  = 12,
    parameter int IDX_W   = 3,
    parameter int EXP_W   = 6
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [IDX_W-1:0]                 cfg_win,
    input  logic [1:0]                       cfg_field,
    input  logic [ADDR_W-1:0]                cfg_wdata,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]   win_mbase,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]   win_tbase,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]   win_mask,
    output logic [NUM_WIN-1:0]               win_en
);

    localparam logic [EXP_W-1:0] EXP_MIN = EXP_W'(MIN_SZ);
    localparam logic [EXP_W-1:0] EXP_MAX = EXP_W'(ADDR_W);

    typedef struct packed {
        logic [NUM_WIN-1:0][ADDR_W-1:0] mbase;
        logic [NUM_WIN-1:0][ADDR_W-1:0] tbase;
        logic [NUM_WIN-1:0][EXP_W-1:0]  sexp;
        logic [NUM_WIN-1:0]             en;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  win_ok;
    logic [EXP_W-1:0] wexp;

    always_comb begin
        regs_d = regs_q;
        win_ok = ({1'b0, cfg_win} < (IDX_W+1)'(NUM_WIN));
        wexp   = cfg_wdata[EXP_W-1:0];
        if (wexp < EXP_MIN)      wexp = EXP_MIN;
        else if (wexp > EXP_MAX) wexp = EXP_MAX;
        if (cfg_we && win_ok) begin
            case (cfg_field_e'(cfg_field))
                FLD_MBASE:  regs_d.mbase[cfg_win] = cfg_wdata;
                FLD_SIZE:   regs_d.sexp[cfg_win]  = wexp;
                FLD_TBASE:  regs_d.tbase[cfg_win] = cfg_wdata;
                FLD_ENABLE: regs_d.en[cfg_win]    = cfg_wdata[0];
                default:    regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.mbase <= '0;
            regs_q.tbase <= '0;
            regs_q.en    <= '0;
            for (int i = 0; i < NUM_WIN; i++) regs_q.sexp[i] <= EXP_MIN;
        end else begin
            regs_q <= regs_d;
        end
    end

    // Mask: ones at and above the size exponent.
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_mask
        for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
            assign win_mask[w][b] = (EXP_W'(b) >= regs_q.sexp[w]);
        end
        p_size_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (regs_q.sexp[w] >= EXP_MIN) && (regs_q.sexp[w] <= EXP_MAX));
    end

    assign win_mbase = regs_q.mbase;
    assign win_tbase = regs_q.tbase;
    assign win_en    = regs_q.en;

    p_enable_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && win_ok && cfg_field == 2'd3)
        |=> (win_en[$past(cfg_win)] == $past(cfg_wdata[0])));

    p_bad_index_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !win_ok) |=> $stable(regs_q));

endmodule

// File: rtl/inb_win_match.sv
module inb_win_match #(
    parameter int NUM_WIN = 6,
    parameter int ADDR_W  = 32
) (
    input  logic [ADDR_W-1:0]               addr,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0]  win_mbase,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0]  win_tbase,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0]  win_mask,
    output logic [NUM_WIN-1:0]              match,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]  xaddr
);

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        assign match[w] = (((addr ^ win_mbase[w]) & win_mask[w]) == '0);
        assign xaddr[w] = (win_tbase[w] & win_mask[w]) | (addr & ~win_mask[w]);
    end

endmodule

// File: rtl/inb_win_pick.sv
module inb_win_pick #(
    parameter int NUM_WIN  = 6,
    parameter int IDX_W    = 3,
    parameter int PRIO_WIN = 5
) (
    input  logic [NUM_WIN-1:0] match,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    logic [IDX_W-1:0] low_idx;

    always_comb begin
        low_idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (match[i]) low_idx = IDX_W'(i);
        end
    end

    assign any = |match;

    if (PRIO_WIN < NUM_WIN) begin : g_pref
        assign idx = match[PRIO_WIN] ? IDX_W'(PRIO_WIN) : low_idx;
    end else begin : g_nopref
        assign idx = low_idx;
    end

endmodule

// File: rtl/inb_addr_xlat.sv
module inb_addr_xlat #(
    parameter int NUM_WIN  = 6,
    parameter int ADDR_W   = 32,
    parameter int MIN_SZ   = 12,
    parameter int PRIO_WIN = NUM_WIN - 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [$clog2(NUM_WIN)-1:0]    cfg_win,
    input  logic [1:0]                    cfg_field,
    input  logic [ADDR_W-1:0]             cfg_wdata,
    input  logic                          lk_valid,
    input  logic [ADDR_W-1:0]             lk_addr_in,
    output logic                          lk_hit,
    output logic                          lk_abort,
    output logic [$clog2(NUM_WIN)-1:0]    lk_win,
    output logic [ADDR_W-1:0]             lk_addr
);

    localparam int IDX_W = $clog2(NUM_WIN);
    localparam int EXP_W = $clog2(ADDR_W + 1);

    logic [NUM_WIN-1:0][ADDR_W-1:0] win_mbase, win_tbase, win_mask, xaddr;
    logic [NUM_WIN-1:0]             win_en, match;
    logic                           any;
    logic [IDX_W-1:0]               sel;

    inb_win_regs #(
        .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .MIN_SZ(MIN_SZ),
        .IDX_W(IDX_W), .EXP_W(EXP_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_field(cfg_field),
        .cfg_wdata(cfg_wdata),
        .win_mbase(win_mbase), .win_tbase(win_tbase),
        .win_mask(win_mask), .win_en(win_en)
    );

    inb_win_match #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) u_match (
        .addr(lk_addr_in),
        .win_mbase(win_mbase), .win_tbase(win_tbase), .win_mask(win_mask),
        .match(match), .xaddr(xaddr)
    );

    inb_win_pick #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W), .PRIO_WIN(PRIO_WIN)) u_pick (
        .match(match), .any(any), .idx(sel)
    );

    always_comb begin
        lk_hit   = lk_valid && any && win_en[sel];
        lk_abort = lk_valid && any && !win_en[sel];
        lk_win   = (lk_valid && any) ? sel : '0;
        lk_addr  = lk_hit ? xaddr[sel] : '0;
    end

    p_hit_abort_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_abort));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_abort));

    p_low_page_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_addr[MIN_SZ-1:0] == lk_addr_in[MIN_SZ-1:0]));

    p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && match == '0) |-> (!lk_hit && !lk_abort && lk_addr == '0));

    p_sel_matches_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit || lk_abort) |-> match[lk_win]);

    if (PRIO_WIN < NUM_WIN) begin : g_prio_chk
        p_pref_win_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (lk_valid && match[PRIO_WIN]) |-> (lk_win == IDX_W'(PRIO_WIN)));
    end

endmodule

// File: tb/sim_inb_addr_xlat.sv
module sim_inb_addr_xlat;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_win = '0;
    logic [1:0]  cfg_field = '0;
    logic [31:0] cfg_wdata = '0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr_in = '0;
    logic        lk_hit, lk_abort;
    logic [2:0]  lk_win;
    logic [31:0] lk_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    inb_addr_xlat u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_field(cfg_field),
        .cfg_wdata(cfg_wdata),
        .lk_valid(lk_valid), .lk_addr_in(lk_addr_in),
        .lk_hit(lk_hit), .lk_abort(lk_abort), .lk_win(lk_win), .lk_addr(lk_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write one field; the write is committed at the rising edge in between.
    task automatic wr(input int w, input int f, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_win = 3'(w); cfg_field = 2'(f); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input int w, input logic [31:0] mb, input int sz,
                         input logic [31:0] tb, input bit en);
        wr(w, 0, mb); wr(w, 1, 32'(sz)); wr(w, 2, tb); wr(w, 3, {31'd0, en});
    endtask

    task automatic look(input string req, input logic [31:0] a, input bit eh,
                        input bit ea, input int ew, input logic [31:0] ead);
        lk_valid = 1'b1; lk_addr_in = a;
        #1;
        chk({req, " hit"},   {31'd0, lk_hit},   {31'd0, eh});
        chk({req, " abort"}, {31'd0, lk_abort}, {31'd0, ea});
        chk({req, " win"},   {29'd0, lk_win},   32'(ew));
        chk({req, " addr"},  lk_addr,           ead);
    endtask

    task automatic t_reset;
        look("R1 reset low page", 32'h0000_0123, 0, 1, 5, 32'h0);
        look("R1 reset outside",  32'h0001_0000, 0, 0, 0, 32'h0);
    endtask

    task automatic t_basic;
        setup(0, 32'h1000_0000, 20, 32'h8000_0000, 1);
        look("R2 R3 inside",  32'h1003_4567, 1, 0, 0, 32'h8003_4567);
        look("R2 R6 outside", 32'h1010_0000, 0, 0, 0, 32'h0);
        look("R3 top edge",   32'h100F_FFFF, 1, 0, 0, 32'h800F_FFFF);
    endtask

    task automatic t_write_timing;
        setup(3, 32'h5000_0000, 16, 32'h6000_0000, 0);
        look("R5 disabled", 32'h5000_1234, 0, 1, 3, 32'h0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_win = 3'd3; cfg_field = 2'd3; cfg_wdata = 32'd1;
        #1;
        chk("R9 before edge abort", {31'd0, lk_abort}, 32'd1);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        chk("R9 after edge hit", {31'd0, lk_hit}, 32'd1);
        chk("R9 after edge addr", lk_addr, 32'h6000_1234);
        wr(6, 0, 32'h2000_0000);
        wr(7, 3, 32'd1);
        look("R9 bad index", 32'h2000_0000, 0, 0, 0, 32'h0);
        look("R1 R9 win5 untouched", 32'h0000_0010, 0, 1, 5, 32'h0);
    endtask

    task automatic t_clamp_low;
        setup(1, 32'h3000_0000, 5, 32'h4000_0000, 1);
        look("R4 clamp in",  32'h3000_0FFF, 1, 0, 1, 32'h4000_0FFF);
        look("R4 clamp out", 32'h3000_1000, 0, 0, 0, 32'h0);
    endtask

    task automatic t_priority;
        setup(4, 32'h7000_0000, 24, 32'hA000_0000, 1);
        setup(5, 32'h7000_0000, 16, 32'h9000_0000, 1);
        look("R7 win5 wins",   32'h7000_1234, 1, 0, 5, 32'h9000_1234);
        look("R2 only win4",   32'h7001_0000, 1, 0, 4, 32'hA001_0000);
        setup(1, 32'h7000_0000, 20, 32'hB000_0000, 1);
        look("R8 lowest",      32'h7001_0000, 1, 0, 1, 32'hB001_0000);
        look("R7 over win1",   32'h7000_1234, 1, 0, 5, 32'h9000_1234);
        wr(5, 3, 32'd0);
        look("R5 R7 disabled pref", 32'h7000_1234, 0, 1, 5, 32'h0);
    endtask

    task automatic t_clamp_high;
        setup(2, 32'h1234_5678, 40, 32'hC000_0000, 1);
        look("R4 full pass", 32'hDEAD_BEEF, 1, 0, 2, 32'hDEAD_BEEF);
        look("R8 win0 over win2", 32'h1000_0040, 1, 0, 0, 32'h8000_0040);
    endtask

    task automatic t_idle;
        lk_valid = 1'b0; lk_addr_in = 32'h1003_4567;
        #1;
        chk("R10 idle hit",   {31'd0, lk_hit},   32'd0);
        chk("R10 idle abort", {31'd0, lk_abort}, 32'd0);
    endtask

    initial begin
        #1;
        lk_valid = 1'b1; lk_addr_in = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_write_timing();
        t_clamp_low();
        t_priority();
        t_clamp_high();
        t_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule